// File: doc/BRIEF.md
# Auto-baud single-wire serial responder

This block is a slave serial port. A host sends one request character at any bit rate inside a configured window. The block takes its bit period from that character, checks the rest of the frame, and replies with two status bytes at the same rate. The status bytes report a 10-bit key-state vector.

Requests can arrive on a shared bidirectional line or on a separate receive input. The two sources are combined, so either one may carry the request. The reply always goes out on the shared line. The block drives that line actively for the start and data bits. It drives the stop-bit level for one clock and then lets go, so that a pull-up holds the line high and the host can drive it again.

A one-cycle clear pulse is sent to an external change flag when a request is accepted, before the reply starts. While the reply is going out, the receiver is held idle, so the block never mistakes its own bytes for a request.

Top module: `swr_responder`

## Requirements
- R1: Only the character 0x50 starts a reply. It must be sent as 8 data bits, LSB first, with one start bit (low), no parity and one stop bit (high). Any other character gives no reply and no clear pulse.
- R2: The bit period P is the length of the first low run divided by 5, rounded down. For 0x50 that run is the start bit plus data bits 0 to 3. The run must be between 5*BIT_MIN and 5*BIT_MAX+4 clocks, where BIT_MIN = CLK_HZ/BAUD_MAX and BIT_MAX = CLK_HZ/BAUD_MIN. A run outside that range gives no reply.
- R3: A request whose stop bit is sampled low gives no reply. The receiver then waits for 11*BIT_MAX clocks of continuous high, after which it accepts requests again.
- R4: Reply byte 0 is 0x40 with bits 0 to 5 taken from keys 0 to 5. Reply byte 1 is 0x40 with bits 0 to 3 taken from keys 6 to 9. All other bits are 0. With no keys active the reply is 0x40, 0x40. With keys 0, 2 and 7 active it is 0x45, 0x42.
- R5: Each reply byte is sent LSB first: a low start bit, 8 data bits, then a high stop bit. Every bit lasts the measured period P.
- R6: The reply start bit begins between 1 and 3 bit periods after the end of the received stop bit.
- R7: Output enable is high for the start and data bits and for the first clock of each stop bit only. It falls only while the line is driven high, and it is low whenever no reply is in progress.
- R8: `chg_clr_o` is a single-cycle pulse. It is issued once for each accepted request, before the reply's start bit.
- R9: A request arriving on `rx_i` produces the same reply on the shared line as one arriving on `line_i`.
- R10: While a reply is in progress the receiver stays idle. No second reply follows a reply unless the host sends a new request.
- R11: During reset and right after it, `line_oe_o` and `chg_clr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sensed level of the shared line |
| line_o | output | 1 | Level driven onto the shared line |
| line_oe_o | output | 1 | Drive enable for the shared line |
| rx_i | input | 1 | Separate request input, idle high |
| keys_i | input | 10 | Key-state vector, 1 = key active |
| chg_clr_o | output | 1 | One-cycle clear pulse for the change flag |

## Verification
The assertions check the following on every cycle:
- the clear pulse is a single cycle and is never issued during a reply;
- the drive enable falls only while the line is driven high;
- every accepted period lies inside the rate window;
- the receiver stays idle while the transmitter is busy.

Some behaviours can only be shown by the bench's scenarios, because the bench acts as a host at several rates on both inputs:
- the decoded reply bytes for each key pattern;
- the turnaround delay and the reply bit rate;
- rejection of wrong characters, bad stop bits and out-of-window rates;
- recovery after a rejected request.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam logic [7:0] REQ_CHAR = 8'h50;
  // Last five samples of a valid request: stop bit followed by data bits 7..4, MSB first.
  localparam logic [4:0] REQ_TAIL = {1'b1, REQ_CHAR[7:4]};
  localparam int unsigned LOW_BITS = 5;  // start bit plus data bits 0..3 of REQ_CHAR

  typedef enum logic [1:0] {R_IDLE, R_LOW, R_SAMP, R_RECOV} rx_st_e;
  typedef enum logic [1:0] {T_IDLE, T_GAP, T_BIT} tx_st_e;

  function automatic logic [15:0] reply_frame(input logic [9:0] k);
    logic [7:0] b0, b1;
    b0 = {2'b01, k[5:0]};
    b1 = {4'b0100, k[9:6]};
    return {b1, b0};
  endfunction
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/swr_rx.sv
module swr_rx
  import swr_pkg::*;
#(
  parameter int unsigned BIT_MIN = 26,
  parameter int unsigned BIT_MAX = 125,
  parameter int unsigned PW      = 7,
  parameter int unsigned LW      = 10,
  parameter int unsigned RW      = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          line_i,    // already synchronised
  output logic          req_o,
  output logic [PW-1:0] period_o,
  output logic          busy_o
);
  localparam logic [LW-1:0] LOW_MIN_C = LW'(LOW_BITS * BIT_MIN);
  localparam logic [LW-1:0] LOW_MAX_C = LW'(LOW_BITS * BIT_MAX + LOW_BITS - 1);
  localparam logic [RW-1:0] RECOV_C   = RW'(11 * BIT_MAX);

  rx_st_e        st_q;
  logic [LW-1:0] low_q;
  logic [2:0]    c5_q;
  logic [PW-1:0] per_q;
  logic [PW-1:0] tmr_q;
  logic [2:0]    idx_q;
  logic [4:0]    tail_q;
  logic [RW-1:0] hi_q;
  logic [4:0]    tail_nx;

  assign tail_nx = {line_i, tail_q[4:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= R_IDLE;
      low_q  <= '0;
      c5_q   <= '0;
      per_q  <= '0;
      tmr_q  <= '0;
      idx_q  <= '0;
      tail_q <= '0;
      hi_q   <= '0;
      req_o  <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (!en_i) begin
        st_q <= R_IDLE;
      end else begin
        unique case (st_q)
          R_IDLE: if (!line_i) begin
            st_q  <= R_LOW;
            low_q <= LW'(1);
            c5_q  <= 3'd1;
            per_q <= '0;
          end
          R_LOW: begin
            if (line_i) begin
              if (low_q >= LOW_MIN_C && low_q <= LOW_MAX_C) begin
                st_q  <= R_SAMP;
                tmr_q <= per_q >> 1;
                idx_q <= '0;
              end else begin
                st_q <= R_RECOV;
                hi_q <= '0;
              end
            end else if (low_q > LOW_MAX_C) begin
              st_q <= R_RECOV;
              hi_q <= '0;
            end else begin
              low_q <= low_q + LW'(1);
              // running divide by five
              if (c5_q == 3'd4) begin
                c5_q  <= '0;
                per_q <= per_q + PW'(1);
              end else begin
                c5_q <= c5_q + 3'd1;
              end
            end
          end
          R_SAMP: begin
            if (tmr_q == '0) begin
              tail_q <= tail_nx;
              tmr_q  <= per_q - PW'(1);
              if (idx_q == 3'd4) begin
                if (!line_i) begin
                  st_q <= R_RECOV;
                  hi_q <= '0;
                end else begin
                  req_o <= (tail_nx == REQ_TAIL);
                  st_q  <= R_IDLE;
                end
              end else begin
                idx_q <= idx_q + 3'd1;
              end
            end else begin
              tmr_q <= tmr_q - PW'(1);
            end
          end
          R_RECOV: begin
            if (!line_i)              hi_q <= '0;
            else if (hi_q == RECOV_C) st_q <= R_IDLE;
            else                      hi_q <= hi_q + RW'(1);
          end
          default: st_q <= R_IDLE;
        endcase
      end
    end
  end

  assign period_o = per_q;
  assign busy_o   = (st_q != R_IDLE);
endmodule

// File: rtl/swr_tx.sv
module swr_tx
  import swr_pkg::*;
#(
  parameter int unsigned PW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] period_i,
  input  logic [9:0]    keys_i,
  output logic          line_o,
  output logic          oe_o,
  output logic          busy_o
);
  tx_st_e        st_q;
  logic [PW-1:0] per_q;
  logic [PW-1:0] tmr_q;
  logic          gap_q;
  logic [3:0]    bit_q;   // 0 start, 1..8 data, 9 stop
  logic          byte_q;
  logic [15:0]   frm_q;
  logic [7:0]    cur;
  logic [2:0]    di;

  assign cur = byte_q ? frm_q[15:8] : frm_q[7:0];
  assign di  = 3'(bit_q - 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      per_q  <= '0;
      tmr_q  <= '0;
      gap_q  <= 1'b0;
      bit_q  <= '0;
      byte_q <= 1'b0;
      frm_q  <= '0;
    end else begin
      unique case (st_q)
        T_IDLE: if (start_i) begin
          st_q  <= T_GAP;
          per_q <= period_i;
          tmr_q <= period_i - PW'(1);
          gap_q <= 1'b0;
          frm_q <= reply_frame(keys_i);
        end
        T_GAP: begin
          if (tmr_q == '0) begin
            tmr_q <= per_q - PW'(1);
            if (gap_q) begin
              st_q   <= T_BIT;
              bit_q  <= '0;
              byte_q <= 1'b0;
            end else begin
              gap_q <= 1'b1;
            end
          end else begin
            tmr_q <= tmr_q - PW'(1);
          end
        end
        T_BIT: begin
          if (tmr_q == '0) begin
            tmr_q <= per_q - PW'(1);
            if (bit_q == 4'd9) begin
              bit_q <= '0;
              if (byte_q) st_q <= T_IDLE;
              else        byte_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 4'd1;
            end
          end else begin
            tmr_q <= tmr_q - PW'(1);
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  always_comb begin
    line_o = 1'b1;
    oe_o   = 1'b0;
    if (st_q == T_BIT) begin
      if (bit_q == 4'd0) begin
        line_o = 1'b0;
        oe_o   = 1'b1;
      end else if (bit_q == 4'd9) begin
        line_o = 1'b1;
        oe_o   = (tmr_q == per_q - PW'(1));  // stop level for one clock, then float
      end else begin
        line_o = cur[di];
        oe_o   = 1'b1;
      end
    end
  end

  assign busy_o = (st_q != T_IDLE);
endmodule

// File: rtl/swr_responder.sv
module swr_responder
  import swr_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned BAUD_MIN    = 8000,
  parameter int unsigned BAUD_MAX    = 38400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       line_o,
  output logic       line_oe_o,
  input  logic       rx_i,
  input  logic [9:0] keys_i,
  output logic       chg_clr_o
);
  localparam int unsigned BIT_MIN = CLK_HZ / BAUD_MAX;
  localparam int unsigned BIT_MAX = CLK_HZ / BAUD_MIN;
  localparam int unsigned PW      = $clog2(BIT_MAX + 1);
  localparam int unsigned LW      = $clog2(LOW_BITS * BIT_MAX + LOW_BITS + 1);
  localparam int unsigned RW      = $clog2(11 * BIT_MAX + 1);

  logic          in_s;
  logic          req_w;
  logic [PW-1:0] per_w;
  logic          rx_busy_w;
  logic          tx_busy_w;

  // either source may carry the request; both idle high
  swr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i & rx_i),
    .q_o   (in_s)
  );

  swr_rx #(
    .BIT_MIN(BIT_MIN), .BIT_MAX(BIT_MAX), .PW(PW), .LW(LW), .RW(RW)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!tx_busy_w),
    .line_i  (in_s),
    .req_o   (req_w),
    .period_o(per_w),
    .busy_o  (rx_busy_w)
  );

  swr_tx #(.PW(PW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req_w),
    .period_i(per_w),
    .keys_i  (keys_i),
    .line_o  (line_o),
    .oe_o    (line_oe_o),
    .busy_o  (tx_busy_w)
  );

  assign chg_clr_o = req_w;
endmodule

// File: rtl/swr_responder_chk.sv
module swr_responder_chk #(
  parameter int unsigned BIT_MIN = 26,
  parameter int unsigned BIT_MAX = 125,
  parameter int unsigned PW      = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          line_o,
  input logic          line_oe_o,
  input logic          chg_clr_o,
  input logic          req_i,
  input logic [PW-1:0] per_i,
  input logic          tx_busy_i,
  input logic          rx_busy_i
);
  p_clr_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_clr_o |=> !chg_clr_o);

  p_clr_before_reply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_clr_o |-> !tx_busy_i && !line_oe_o);

  p_release_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_oe_o) |-> $past(line_o));

  p_period_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (per_i >= PW'(BIT_MIN)) && (per_i <= PW'(BIT_MAX)));

  p_rx_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !rx_busy_i);

  p_reply_needs_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_i) |-> $past(req_i));
endmodule

bind swr_responder swr_responder_chk #(
  .BIT_MIN(BIT_MIN), .BIT_MAX(BIT_MAX), .PW(PW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .line_o   (line_o),
  .line_oe_o(line_oe_o),
  .chg_clr_o(chg_clr_o),
  .req_i    (req_w),
  .per_i    (per_w),
  .tx_busy_i(tx_busy_w),
  .rx_busy_i(rx_busy_w)
);

// File: tb/sim_swr_responder.sv
module sim_swr_responder;
  // scaled clock rate: the bit period window becomes 26..125 clocks
  localparam int unsigned T_CLK_HZ = 1_000_000;

  typedef struct packed {
    int         p;
    bit         via_rx;
    logic [9:0] k;
    logic [7:0] e0;
    logic [7:0] e1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{60,  1'b0, 10'h000, 8'h40, 8'h40},
    '{60,  1'b0, 10'h085, 8'h45, 8'h42},
    '{27,  1'b0, 10'h3FF, 8'h7F, 8'h4F},
    '{124, 1'b0, 10'h2AA, 8'h6A, 8'h4A},
    '{45,  1'b1, 10'h155, 8'h55, 8'h45},
    '{90,  1'b1, 10'h085, 8'h45, 8'h42}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_line = 1'b1;
  logic       host_rx = 1'b1;
  logic [9:0] keys = '0;
  logic       line_o, line_oe, chg_clr;
  wire        line_w = line_oe ? line_o : host_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int clr_cnt = 0;
  int clr_cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (chg_clr) begin clr_cnt++; clr_cyc = cyc; end

  swr_responder #(.CLK_HZ(T_CLK_HZ), .BAUD_MIN(8000), .BAUD_MAX(38400)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line_w), .line_o(line_o),
    .line_oe_o(line_oe), .rx_i(host_rx), .keys_i(keys), .chg_clr_o(chg_clr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input bit via_rx, input logic v);
    if (via_rx) host_rx = v;
    else        host_line = v;
  endtask

  task automatic send_byte(input logic [7:0] v, input int p, input bit via_rx, input bit stop_ok);
    drv(via_rx, 1'b0);
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv(via_rx, v[i]);
      repeat (p) @(negedge clk);
    end
    drv(via_rx, stop_ok);
    repeat (p) @(negedge clk);
    drv(via_rx, 1'b1);
  endtask

  task automatic wait_fall(input int limit, output int waited, output bit found);
    found = 1'b0;
    waited = 0;
    for (int i = 0; i < limit && !found; i++) begin
      @(negedge clk);
      waited++;
      if (!line_w) found = 1'b1;
    end
  endtask

  task automatic get_byte(input int p, output logic [7:0] v, output bit stop_ok, output bit rel);
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (p) @(negedge clk);
      v[i] = line_w;
    end
    repeat (p) @(negedge clk);
    stop_ok = line_w;
    rel = !line_oe;
  endtask

  task automatic expect_none(input int win, input string tag);
    int seen = 0;
    repeat (win) begin
      @(negedge clk);
      if (line_oe || chg_clr) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic run_req(input int p, input bit via_rx, input logic [9:0] k,
                         input logic [7:0] e0, input logic [7:0] e1, input string tag);
    int w, t0, t1, base;
    bit found, st, rel;
    logic [7:0] b;
    keys = k;
    base = clr_cnt;
    send_byte(8'h50, p, via_rx, 1'b1);
    wait_fall(4 * p, w, found);
    chk(found, {tag, " R1 reply present"}, found, 1);
    if (!found) return;
    t0 = cyc;
    chk(w >= p && w <= 3 * p, {tag, " R6 turnaround"}, w, 2 * p);
    chk(clr_cnt == base + 1 && clr_cyc < t0, {tag, " R8 clear pulse"}, clr_cnt - base, 1);
    get_byte(p, b, st, rel);
    chk(b == e0, {tag, " R4 byte0"}, b, e0);
    chk(st && rel, {tag, " R7 stop/release"}, {st, rel}, 3);
    wait_fall(3 * p, w, found);
    t1 = cyc;
    chk(found && (t1 - t0 - 10 * p) <= 12 && (10 * p - (t1 - t0)) <= 12,
        {tag, " R5 byte spacing"}, t1 - t0, 10 * p);
    get_byte(p, b, st, rel);
    chk(b == e1, {tag, " R4 byte1"}, b, e1);
    chk(st && rel, {tag, " R7 stop/release"}, {st, rel}, 3);
    expect_none(1000, {tag, " R10 no extra reply"});
  endtask

  task automatic run_all();
    repeat (5) @(negedge clk);
    chk(!line_oe && !chg_clr, "R11 in reset", {line_oe, chg_clr}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!line_oe && !chg_clr, "R11 after reset", {line_oe, chg_clr}, 0);

    for (int i = 0; i < 6; i++)
      run_req(VECS[i].p, VECS[i].via_rx, VECS[i].k, VECS[i].e0, VECS[i].e1,
              VECS[i].via_rx ? "R9 rx" : "line");

    keys = 10'h085;
    send_byte(8'h70, 60, 1'b0, 1'b1);
    expect_none(3000, "R1 char 0x70");
    send_byte(8'h51, 60, 1'b0, 1'b1);
    expect_none(3000, "R1 char 0x51");
    send_byte(8'h50, 60, 1'b0, 1'b0);
    expect_none(3000, "R3 bad stop");
    send_byte(8'h50, 20, 1'b0, 1'b1);
    expect_none(3000, "R2 too fast");
    send_byte(8'h50, 140, 1'b1, 1'b1);
    expect_none(3000, "R2 too slow");
    run_req(60, 1'b0, 10'h201, 8'h41, 8'h48, "R3 recovery");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog act=%0d exp=0", cyc);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule